// File: doc/BRIEF.md
# Triggered Dual-Channel Capture Buffer

This block sits behind a two-channel converter front end. On each clock with `sampleValid` high it takes one calibrated sample from each channel, packs the pair into a 32-bit word and may store that word in an on-chip sample memory. A start command arms the block. Capture then begins at once, or it waits for a threshold crossing on a chosen channel. In the triggered mode the memory acts as a ring, so a programmable number of words from before the event are kept.

After the programmed number of words has been captured, the block stops taking samples and raises a full flag. If enabled, it also raises an interrupt. The stored words then leave, oldest first, over an AXI4-Stream master toward a DMA engine. TLAST marks the final word. Acceptance of that word clears the full flag and returns the block to idle. Software controls the block through a small register port with a write strobe and a combinational read.

Top module: `trig_capture_buf`

## Requirements
- R1: Each stored and streamed word is {channel A sample, 2'b00, channel B sample, 2'b00}, with channel A in bits [31:18] and channel B in bits [15:2].
- R2: A capture streams exactly `length` words, with TLAST high only on the final word. The length register holds 1 to 2^ADDR_W - 1.
- R3: With config bit0 = 0 (immediate mode), the first `length` valid samples after the start command are stored, and the window register is ignored.
- R4: With config bit0 = 1 (triggered mode), the trigger is a signed threshold crossing on the channel picked by config bit2 (0 = A, 1 = B). With config bit1 = 0 it is rising: previous sample below the level and current at or above it. With bit1 = 1 it is falling: previous above the level and current at or below it. The previous sample must have arrived after the start.
- R5: In triggered mode, a trigger counts only once `window` samples have been stored since the start. The trigger sample is the first post-trigger word. If the trigger is sample t, the stream carries samples t-window through t+length-window-1, in order.
- R6: When the last word is stored, the full flag rises. While it is high, incoming samples are not stored, and the memory contents stay unchanged.
- R7: The interrupt output equals full AND config bit3 (interrupt enable).
- R8: The stream holds TVALID and TDATA steady while TREADY is low. Full and the interrupt clear once the word carrying TLAST is accepted.
- R9: Writing command bit1 (stop) while armed or capturing returns the block to idle with nothing stored for output. The same write while full has no effect.
- R10: Writing command bit0 (start) has no effect when length is zero, or in triggered mode when window is not less than length.
- R11: Register map: address 0 is command (write only). Address 1 is config [3:0]. Address 2 is level (14-bit two's complement). Address 3 is length. Address 4 is window. Address 5 is status (bit0 busy = armed or capturing, bit1 full). Addresses 1 to 4 read back their written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A sample pair is present this cycle |
| chanA | input | SAMPLE_W | Channel A sample, two's complement |
| chanB | input | SAMPLE_W | Channel B sample, two's complement |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| mTvalid | output | 1 | Stream word valid |
| mTready | input | 1 | Stream word accepted when high with mTvalid |
| mTdata | output | 32 | Stream word |
| mTlast | output | 1 | Final word of the capture |
| bufFull | output | 1 | Capture complete, data waiting to drain |
| irqOut | output | 1 | Buffer-full interrupt |

## Verification
The assertions assume that software leaves length, window and level untouched between a start and the end of the drain. They also assume that window is less than length whenever triggered mode is started. The window-bound and write-range checks depend on both. The bench writes the configuration only while the block is idle. It draws the window from 0 to length-1, and it keeps the level inside the swing of the triangle test waveforms, so that every armed run meets a trigger. The one exception is the stop test, where the level is deliberately out of reach.

// File: rtl/tcb_pkg.sv
`timescale 1ns/1ps
package tcb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_CAPT, ST_FULL} capState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;    // store current sample pair
    logic ptrClr;  // restart write pointer and trigger history
    logic rdLoad;  // read pointer takes the oldest retained slot
    logic rdAdv;   // read pointer steps to the next slot
  } capStrobe_t;
endpackage

// File: rtl/tcb_regs.sv
`timescale 1ns/1ps
module tcb_regs #(
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [2:0]          regAddr,
  input  logic [31:0]         regWdata,
  input  logic                busy,
  input  logic                full,
  output logic                startPulse,
  output logic                stopPulse,
  output logic                cfgMode,
  output logic                cfgEdge,
  output logic                cfgChan,
  output logic                cfgIrqEn,
  output logic [SAMPLE_W-1:0] level,
  output logic [ADDR_W-1:0]   bufLen,
  output logic [ADDR_W-1:0]   winPos,
  output logic [31:0]         regRdata
);
  localparam logic [2:0] A_CMD = 3'd0, A_CFG = 3'd1, A_LVL = 3'd2,
                         A_LEN = 3'd3, A_WIN = 3'd4, A_STAT = 3'd5;

  assign startPulse = regWe && (regAddr == A_CMD) && regWdata[0];
  assign stopPulse  = regWe && (regAddr == A_CMD) && regWdata[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {cfgIrqEn, cfgChan, cfgEdge, cfgMode} <= '0;
      level  <= '0;
      bufLen <= '0;
      winPos <= '0;
    end else if (regWe) begin
      case (regAddr)
        A_CFG: {cfgIrqEn, cfgChan, cfgEdge, cfgMode} <= regWdata[3:0];
        A_LVL: level  <= regWdata[SAMPLE_W-1:0];
        A_LEN: bufLen <= regWdata[ADDR_W-1:0];
        A_WIN: winPos <= regWdata[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CFG:  regRdata[3:0]          = {cfgIrqEn, cfgChan, cfgEdge, cfgMode};
      A_LVL:  regRdata[SAMPLE_W-1:0] = level;
      A_LEN:  regRdata[ADDR_W-1:0]   = bufLen;
      A_WIN:  regRdata[ADDR_W-1:0]   = winPos;
      A_STAT: regRdata[1:0]          = {full, busy};
      default: ;
    endcase
  end
endmodule

// File: rtl/tcb_ctrl.sv
`timescale 1ns/1ps
module tcb_ctrl
  import tcb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              stopPulse,
  input  logic              cfgMode,
  input  logic [ADDR_W-1:0] bufLen,
  input  logic [ADDR_W-1:0] winPos,
  input  logic              sampleValid,
  input  logic              trigHit,
  input  logic              mTready,
  output capStrobe_t        st,
  output logic              busy,
  output logic              full,
  output logic              mTvalid,
  output logic              mTlast
);
  capState_e         state;
  logic [ADDR_W-1:0] preCnt, postCnt, rdCnt, postTarget;
  logic              startOk, fire, lastWr, lastRd;

  assign postTarget = cfgMode ? (bufLen - winPos) : bufLen;
  assign startOk    = (state == ST_IDLE) && startPulse && (bufLen != '0) &&
                      (!cfgMode || (winPos < bufLen));
  assign fire       = (state == ST_ARMED) && !stopPulse && sampleValid &&
                      (preCnt == winPos) && trigHit;
  assign lastWr     = (state == ST_CAPT) && !stopPulse && sampleValid &&
                      (postCnt == postTarget - 1'b1);
  assign lastRd     = (rdCnt == bufLen - 1'b1);

  assign busy    = (state == ST_ARMED) || (state == ST_CAPT);
  assign full    = (state == ST_FULL);
  assign mTvalid = full;
  assign mTlast  = full && lastRd;

  always_comb begin
    st = '0;
    unique case (state)
      ST_IDLE:  st.ptrClr = startOk;
      ST_ARMED: begin
        st.wrEn   = sampleValid && !stopPulse;
        st.rdLoad = fire && (postTarget == 1);
      end
      ST_CAPT:  begin
        st.wrEn   = sampleValid && !stopPulse;
        st.rdLoad = lastWr;
      end
      ST_FULL:  st.rdAdv = mTready;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      preCnt  <= '0;
      postCnt <= '0;
      rdCnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (startOk) begin
          preCnt  <= '0;
          postCnt <= '0;
          rdCnt   <= '0;
          state   <= cfgMode ? ST_ARMED : ST_CAPT;
        end
        ST_ARMED: begin
          if (stopPulse) state <= ST_IDLE;
          else if (fire) begin
            postCnt <= 1;
            state   <= (postTarget == 1) ? ST_FULL : ST_CAPT;
          end else if (sampleValid && (preCnt != winPos))
            preCnt <= preCnt + 1'b1;
        end
        ST_CAPT: begin
          if (stopPulse) state <= ST_IDLE;
          else if (sampleValid) begin
            postCnt <= postCnt + 1'b1;
            if (lastWr) state <= ST_FULL;
          end
        end
        ST_FULL: if (mTready) begin
          if (lastRd) state <= ST_IDLE;
          else        rdCnt <= rdCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  pre_window_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED) |-> (preCnt <= winPos));

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && !(mTready && mTlast)) |=> full);

  // R9
  stop_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopPulse && busy) |=> (!busy && !full));
endmodule

// File: rtl/tcb_dpath.sv
`timescale 1ns/1ps
module tcb_dpath
  import tcb_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  capStrobe_t          st,
  input  logic                full,
  input  logic [ADDR_W-1:0]   bufLen,
  input  logic                cfgEdge,
  input  logic                cfgChan,
  input  logic [SAMPLE_W-1:0] level,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] chanA,
  input  logic [SAMPLE_W-1:0] chanB,
  output logic                trigHit,
  output logic [31:0]         mTdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAD   = 16 - SAMPLE_W;

  logic [31:0]                mem [DEPTH];
  logic [ADDR_W-1:0]          wrPtr, rdPtr, wrNext, rdNext;
  logic signed [SAMPLE_W-1:0] prevSel, curSel, lvl;
  logic                       havePrev, rising, falling;
  logic [31:0]                word;

  assign word   = {chanA, {PAD{1'b0}}, chanB, {PAD{1'b0}}};
  assign wrNext = (wrPtr == bufLen - 1'b1) ? '0 : wrPtr + 1'b1;
  assign rdNext = (rdPtr == bufLen - 1'b1) ? '0 : rdPtr + 1'b1;

  assign curSel  = cfgChan ? $signed(chanB) : $signed(chanA);
  assign lvl     = $signed(level);
  assign rising  = (prevSel < lvl) && (curSel >= lvl);
  assign falling = (prevSel > lvl) && (curSel <= lvl);
  assign trigHit = havePrev && (cfgEdge ? falling : rising);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      prevSel  <= '0;
      havePrev <= 1'b0;
    end else begin
      if (st.ptrClr) begin
        wrPtr    <= '0;
        havePrev <= 1'b0;
      end else begin
        if (st.wrEn) wrPtr <= wrNext;
        if (sampleValid) begin
          prevSel  <= curSel;
          havePrev <= 1'b1;
        end
      end
      if (st.rdLoad)     rdPtr <= wrNext;
      else if (st.rdAdv) rdPtr <= rdNext;
    end
  end

  always_ff @(posedge clk) begin
    if (st.wrEn) mem[wrPtr] <= word;
  end

  assign mTdata = mem[rdPtr];

  // R6
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !st.wrEn);

  // R2
  wr_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.wrEn |-> (wrPtr < bufLen));
endmodule

// File: rtl/trig_capture_buf.sv
`timescale 1ns/1ps
module trig_capture_buf
  import tcb_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] chanA,
  input  logic [SAMPLE_W-1:0] chanB,
  input  logic                regWe,
  input  logic [2:0]          regAddr,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  output logic                mTvalid,
  input  logic                mTready,
  output logic [31:0]         mTdata,
  output logic                mTlast,
  output logic                bufFull,
  output logic                irqOut
);
  capStrobe_t          st;
  logic                startPulse, stopPulse, cfgMode, cfgEdge, cfgChan, cfgIrqEn;
  logic                busy, trigHit;
  logic [SAMPLE_W-1:0] level;
  logic [ADDR_W-1:0]   bufLen, winPos;

  tcb_regs #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .busy(busy), .full(bufFull), .startPulse(startPulse), .stopPulse(stopPulse),
    .cfgMode(cfgMode), .cfgEdge(cfgEdge), .cfgChan(cfgChan), .cfgIrqEn(cfgIrqEn),
    .level(level), .bufLen(bufLen), .winPos(winPos), .regRdata(regRdata));

  tcb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPulse(stopPulse),
    .cfgMode(cfgMode), .bufLen(bufLen), .winPos(winPos), .sampleValid(sampleValid),
    .trigHit(trigHit), .mTready(mTready), .st(st), .busy(busy), .full(bufFull),
    .mTvalid(mTvalid), .mTlast(mTlast));

  tcb_dpath #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .full(bufFull), .bufLen(bufLen),
    .cfgEdge(cfgEdge), .cfgChan(cfgChan), .level(level), .sampleValid(sampleValid),
    .chanA(chanA), .chanB(chanB), .trigHit(trigHit), .mTdata(mTdata));

  assign irqOut = bufFull && cfgIrqEn;

  // R8
  stream_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mTvalid && !mTready) |=> (mTvalid && $stable(mTdata)));

  // R7
  irq_needs_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> bufFull);

  // R2
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    mTlast |-> mTvalid);
endmodule

// File: tb/trig_capture_buf_bench.sv
`timescale 1ns/1ps
module trig_capture_buf_bench;
  localparam int AW = 4;
  localparam int SW = 14;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleValid = 1'b0;
  logic [SW-1:0] chanA = '0, chanB = '0;
  logic          regWe = 1'b0;
  logic [2:0]    regAddr = '0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic          mTvalid, mTlast, bufFull, irqOut;
  logic          mTready = 1'b0;
  logic [31:0]   mTdata;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  trig_capture_buf #(.ADDR_W(AW), .SAMPLE_W(SW)) u_trig_capture_buf (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .chanA(chanA), .chanB(chanB),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .mTvalid(mTvalid), .mTready(mTready), .mTdata(mTdata), .mTlast(mTlast),
    .bufFull(bufFull), .irqOut(irqOut));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int tri_wave(input int x);
    int a = x % 800;
    return (a < 400) ? a - 200 : 600 - a;
  endfunction
  function automatic int sampA(input int k); return tri_wave(k * 37); endfunction
  function automatic int sampB(input int k); return tri_wave(k * 53 + 300); endfunction
  function automatic logic [31:0] packWord(input int k);
    logic [13:0] a = sampA(k);
    logic [13:0] b = sampB(k);
    return {a, 2'b00, b, 2'b00};
  endfunction
  function automatic bit crossed(input bit fallEdge, input int p, input int c, input int l);
    return fallEdge ? (p > l && c <= l) : (p < l && c >= l);
  endfunction

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic sendJunk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleValid = 1'b1; chanA = 14'h1555; chanB = 14'h2AAA;
    end
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  // one full capture and drain; expected stream computed from the requirements
  task automatic runCase(input bit mode, input bit fallEdge, input bit chan,
                         input int lvl, input int len, input int win,
                         input bit gaps, input bit slowReady, input bit irqEn,
                         input bit stallFull, input bit stopInFull);
    int t, w, s0, k, cyc, j;
    bit found;
    logic [31:0] rd;
    regWrite(3'd1, {28'd0, irqEn, chan, fallEdge, mode});
    regWrite(3'd2, 32'(lvl));
    regWrite(3'd3, 32'(len));
    regWrite(3'd4, 32'(win));
    regWrite(3'd0, 32'd1);
    if (mode) begin
      w = win; found = 0; t = 0;
      for (int n = (win > 1 ? win : 1); n < 4000 && !found; n++) begin
        int p = chan ? sampB(n - 1) : sampA(n - 1);
        int c = chan ? sampB(n) : sampA(n);
        if (crossed(fallEdge, p, c, lvl)) begin found = 1; t = n; end
      end
    end else begin
      w = 0; t = 0;
    end
    s0 = t - w;
    k = 0; cyc = 0;
    forever begin
      @(negedge clk);
      if (sampleValid) k++;
      if (bufFull || cyc > 6000) begin sampleValid = 1'b0; break; end
      sampleValid = gaps ? (cyc % 3 != 2) : 1'b1;
      chanA = 14'(sampA(k)); chanB = 14'(sampB(k));
      cyc++;
    end
    // R3 R5: number of samples consumed before full
    chk(k == s0 + len, mode ? "R5" : "R3", "samples consumed", k, s0 + len);
    chk(bufFull == 1'b1, "R6", "full after capture", bufFull, 1);
    chk(irqOut == irqEn, "R7", "interrupt level", irqOut, irqEn);
    if (stallFull) begin
      sendJunk(6);
      chk(bufFull == 1'b1, "R6", "full while samples arrive", bufFull, 1);
    end
    if (stopInFull) begin
      regWrite(3'd0, 32'd2);
      regRead(3'd5, rd);
      chk(rd[1:0] == 2'b10, "R9", "stop while full ignored", rd[1:0], 2);
    end
    j = 0; cyc = 0;
    while (j < len && cyc < 2000) begin
      @(negedge clk);
      mTready = slowReady ? (cyc % 2 == 1) : 1'b1;
      #1;
      if (!mTvalid) chk(0, "R8", "valid dropped during drain", 0, 1);
      else if (mTready) begin
        chk(mTdata == packWord(s0 + j), mode ? "R5" : "R1", "stream word", mTdata, packWord(s0 + j));
        chk(mTlast == (j == len - 1), "R2", "tlast position", mTlast, j == len - 1);
        j++;
      end
      cyc++;
    end
    @(negedge clk);
    mTready = 1'b0;
    #1;
    chk(j == len, "R2", "words drained", j, len);
    chk(!bufFull && !irqOut && !mTvalid, "R8", "full/irq/valid after last",
        {bufFull, irqOut, mTvalid}, 0);
  endtask

  initial begin
    #(150000 * 5);
    failures++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(!mTvalid && !bufFull && !irqOut && !mTlast, "R11", "reset outputs",
        {mTvalid, bufFull, irqOut, mTlast}, 0);
    regRead(3'd5, rd);
    chk(rd == 0, "R11", "reset status", rd, 0);

    // R11 register readback
    regWrite(3'd1, 32'hA);
    regWrite(3'd2, 32'h2ABC);
    regWrite(3'd3, 32'd9);
    regWrite(3'd4, 32'd5);
    regRead(3'd1, rd); chk(rd == 32'hA, "R11", "config readback", rd, 32'hA);
    regRead(3'd2, rd); chk(rd == 32'h2ABC, "R11", "level readback", rd, 32'h2ABC);
    regRead(3'd3, rd); chk(rd == 9, "R11", "length readback", rd, 9);
    regRead(3'd4, rd); chk(rd == 5, "R11", "window readback", rd, 5);

    // R10 start ignored with zero length
    regWrite(3'd1, 32'd0);
    regWrite(3'd3, 32'd0);
    regWrite(3'd0, 32'd1);
    regRead(3'd5, rd); chk(rd[0] == 0, "R10", "start with zero length", rd[0], 0);
    sendJunk(20);
    chk(!bufFull, "R10", "no capture with zero length", bufFull, 0);

    // R10 start ignored when window not below length in triggered mode
    regWrite(3'd1, 32'd1);
    regWrite(3'd3, 32'd4);
    regWrite(3'd4, 32'd4);
    regWrite(3'd0, 32'd1);
    regRead(3'd5, rd); chk(rd[0] == 0, "R10", "start with window=length", rd[0], 0);

    // R9 stop while armed with an unreachable level
    regWrite(3'd2, 32'd3000);
    regWrite(3'd4, 32'd1);
    regWrite(3'd0, 32'd1);
    regRead(3'd5, rd); chk(rd[1:0] == 2'b01, "R9", "armed busy", rd[1:0], 1);
    sendJunk(10);
    regWrite(3'd0, 32'd2);
    regRead(3'd5, rd); chk(rd[1:0] == 2'b00, "R9", "idle after stop", rd[1:0], 0);
    sendJunk(30);
    chk(!bufFull && !mTvalid, "R9", "nothing stored after stop", {bufFull, mTvalid}, 0);

    // R3 immediate mode sweep over every length
    for (int len = 1; len < (1 << AW); len++)
      runCase(1'b0, 1'b0, 1'b0, 0, len, len % 3, len[0], len[1], len[0], len == 3, len == 5);

    // R4 R5 triggered sweep: every length, every window, both edges
    for (int len = 1; len < (1 << AW); len++)
      for (int win = 0; win < len; win++)
        for (int e = 0; e < 2; e++)
          runCase(1'b1, e[0], (len + win) % 2 == 1, e ? -40 : 17, len, win,
                  win[0], len[0], e[0], (win == 2 && e == 0), (win == 1 && e == 1));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule